// File: doc/BRIEF.md
# Per-Channel Oversampling Select and Software Reset Control

This block sits beside the channels of a multi-channel UART and holds two byte-wide global configuration registers. The first picks, per channel, whether the receiver and transmitter run at 16x or 8x oversampling. The block applies that choice itself by dividing a shared 16x baud tick down to one bit-time tick per channel. A channel in 8x mode therefore gets its bit ticks twice as often, and its data rate doubles.

The second register lets software reset a single channel. Writing a one to a channel's bit produces a reset pulse exactly one clock wide to that channel, and the bit then returns to zero without further action. A channel reset also restarts that channel's bit-time divider. It leaves the oversampling choice alone, because only the device reset clears the global registers.

Registers sit at a one-bit address: address 0 is the oversampling-select register and address 1 is the channel-reset register. Writes take effect at the clock edge where `wr_en` is high. Reads are combinational from `rd_addr`.

Top module: `uart_chan_cfg`

## Requirements
- R1: After the device reset (active-low, synchronous), both registers read 0x00, and `samp_8x`, `chan_rst` and `bit_tick` are all zero.
- R2: A write to address 0 stores bit c as the mode of channel c (0 = 16x, 1 = 8x). The stored value drives `samp_8x[c]` from the next cycle and reads back at address 0.
- R3: In 16x mode a channel's `bit_tick` is high for one cycle, in the cycle after every 16th counted `baud_tick`.
- R4: In 8x mode a channel's `bit_tick` is high for one cycle, in the cycle after every 8th counted `baud_tick`. This doubles the bit rate.
- R5: When a channel's mode bit changes value, its divider restarts from zero. A `baud_tick` in the first cycle the new mode is visible is not counted.
- R6: A write to address 1 with bit c set drives `chan_rst[c]` high for exactly the next cycle. Address 1 reads bit c as 1 only in that cycle and as 0 afterwards.
- R7: Writing 0 to a reset bit produces no pulse. Writing 1 to both bits pulses both channels in the same cycle.
- R8: Bits 7..2 of both registers ignore writes and always read 0.
- R9: A channel reset pulse leaves that channel's `samp_8x` bit unchanged.
- R10: A channel reset pulse restarts that channel's divider. A `baud_tick` in the pulse cycle is not counted, and no `bit_tick` follows the pulse in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low device reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address (0 mode, 1 reset) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 1 | Read address (0 mode, 1 reset) |
| rd_data | output | 8 | Read data |
| baud_tick | input | 1 | Shared 16x baud tick enable |
| samp_8x | output | 2 | Per-channel 8x mode select |
| chan_rst | output | 2 | Per-channel one-clock reset pulse |
| bit_tick | output | 2 | Per-channel bit-time tick |

## Verification
The interesting collision is between a channel reset pulse and the completion of that channel's bit-time count. If both land in the same cycle, the reset must win and the tick must not appear. The sweep writes every byte value to the reset register while the baud tick keeps running, so pulses land at every divider phase, including the final count. Each cycle is judged against an arithmetic model of the divider that applies the restart rule, and the same model covers mode changes that arrive mid-count.

// File: rtl/uart_cfg_pkg.sv
// Package: shared constants for the UART global configuration block.
// Assumes a one-bit register address and byte-wide registers.
package uart_cfg_pkg;
    localparam int REG_W  = 8;
    localparam int ADDR_W = 1;
    localparam logic [ADDR_W-1:0] ADDR_MODE = 1'b0;
    localparam logic [ADDR_W-1:0] ADDR_CRST = 1'b1;
    localparam int DIV_16X = 16;
    localparam int DIV_8X  = DIV_16X / 2;
endpackage

// File: rtl/ucfg_regs.sv
// Module: ucfg_regs
// Holds the oversampling-select register and the self-clearing
// channel-reset register. Unused (reserved) bits are masked to zero.
// Assumes NUM_CH <= REG_W.
module ucfg_regs
    import uart_cfg_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  rd_data,
    output logic [NUM_CH-1:0] mode_q,
    output logic [NUM_CH-1:0] crst_q
);
    localparam logic [REG_W-1:0] CH_MASK = REG_W'((1 << NUM_CH) - 1);

    logic [REG_W-1:0] mode_r;
    logic [REG_W-1:0] crst_r;
    logic             wr_mode;
    logic             wr_crst;

    // Decode the write strobe per register.
    always_comb begin
        wr_mode = wr_en && (wr_addr == ADDR_MODE);
        wr_crst = wr_en && (wr_addr == ADDR_CRST);
    end

    // Mode register: loads masked data, cleared only by device reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_r <= '0;
        end else if (wr_mode) begin
            mode_r <= wr_data & CH_MASK;
        end
    end

    // Reset register: holds written ones for a single cycle, then clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crst_r <= '0;
        end else if (wr_crst) begin
            crst_r <= wr_data & CH_MASK;
        end else begin
            crst_r <= '0;
        end
    end

    // Read mux and per-channel outputs.
    always_comb begin
        rd_data = (rd_addr == ADDR_CRST) ? crst_r : mode_r;
        mode_q  = mode_r[NUM_CH-1:0];
        crst_q  = crst_r[NUM_CH-1:0];
    end
endmodule

// File: rtl/ucfg_tick_div.sv
// Module: ucfg_tick_div
// Divides the shared 16x baud tick by 16 or by 8 into one bit-time tick.
// The phase restarts on a mode change or on a channel reset pulse; a baud
// tick arriving in a restart cycle is dropped. The output is registered.
module ucfg_tick_div
    import uart_cfg_pkg::*;
#(
    parameter int DIV_HI = DIV_16X
) (
    input  logic clk,
    input  logic rst_n,
    input  logic baud_tick,
    input  logic mode_8x,
    input  logic restart,
    output logic bit_tick
);
    localparam int DIV_LO = DIV_HI / 2;
    localparam int CNT_W  = $clog2(DIV_HI);
    localparam logic [CNT_W-1:0] LAST_HI = CNT_W'(DIV_HI - 1);
    localparam logic [CNT_W-1:0] LAST_LO = CNT_W'(DIV_LO - 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;
    logic             mode_seen;
    logic             tick_r;

    // Select the terminal count for the current mode.
    always_comb begin
        last = mode_8x ? LAST_LO : LAST_HI;
    end

    // Count baud ticks, restart on mode change or channel reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            mode_seen <= 1'b0;
            tick_r    <= 1'b0;
        end else begin
            tick_r <= 1'b0;
            if (restart || (mode_8x != mode_seen)) begin
                cnt       <= '0;
                mode_seen <= mode_8x;
            end else if (baud_tick) begin
                if (cnt == last) begin
                    cnt    <= '0;
                    tick_r <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // Drive the registered tick.
    always_comb begin
        bit_tick = tick_r;
    end
endmodule

// File: rtl/uart_chan_cfg.sv
// Module: uart_chan_cfg
// Global per-channel configuration: oversampling select and software
// channel reset, plus one bit-time divider per channel.
// Assumes baud_tick is a single-cycle enable at 16x the nominal bit rate.
module uart_chan_cfg
    import uart_cfg_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  rd_data,
    input  logic              baud_tick,
    output logic [NUM_CH-1:0] samp_8x,
    output logic [NUM_CH-1:0] chan_rst,
    output logic [NUM_CH-1:0] bit_tick
);
    logic [NUM_CH-1:0] mode_q;
    logic [NUM_CH-1:0] crst_q;

    // Register file.
    ucfg_regs #(.NUM_CH(NUM_CH)) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .mode_q  (mode_q),
        .crst_q  (crst_q)
    );

    // One divider per channel.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        ucfg_tick_div #(.DIV_HI(DIV_16X)) i_div (
            .clk       (clk),
            .rst_n     (rst_n),
            .baud_tick (baud_tick),
            .mode_8x   (mode_q[c]),
            .restart   (crst_q[c]),
            .bit_tick  (bit_tick[c])
        );
    end

    // Route register state to the channels.
    always_comb begin
        samp_8x  = mode_q;
        chan_rst = crst_q;
    end
endmodule

// File: rtl/uart_chan_cfg_chk.sv
// Module: uart_chan_cfg_chk
// Checker bound to uart_chan_cfg; observes ports only.
module uart_chan_cfg_chk
    import uart_cfg_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [REG_W-1:0]  wr_data,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [REG_W-1:0]  rd_data,
    input logic              baud_tick,
    input logic [NUM_CH-1:0] samp_8x,
    input logic [NUM_CH-1:0] chan_rst,
    input logic [NUM_CH-1:0] bit_tick
);
    AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[REG_W-1:NUM_CH] == '0); // R8

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        AST_PULSE_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
            chan_rst[c] |-> $past(wr_en && (wr_addr == ADDR_CRST) && wr_data[c])); // R6
        AST_ZERO_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && (wr_addr == ADDR_CRST) && !wr_data[c]) |=> !chan_rst[c]); // R7
        AST_MODE_HELD_IN_RST: assert property (@(posedge clk) disable iff (!rst_n)
            chan_rst[c] |-> $stable(samp_8x[c])); // R9
        AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
            bit_tick[c] |=> !bit_tick[c]); // R3
        AST_TICK_FROM_BAUD: assert property (@(posedge clk) disable iff (!rst_n)
            bit_tick[c] |-> $past(baud_tick)); // R4
        AST_NO_TICK_AFTER_RST: assert property (@(posedge clk) disable iff (!rst_n)
            chan_rst[c] |=> !bit_tick[c]); // R10
    end
endmodule

bind uart_chan_cfg uart_chan_cfg_chk #(.NUM_CH(NUM_CH)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .baud_tick (baud_tick),
    .samp_8x   (samp_8x),
    .chan_rst  (chan_rst),
    .bit_tick  (bit_tick)
);

// File: tb/test_uart_chan_cfg.sv
// Bench: sweeps mode values, reset-register values and tick patterns,
// comparing every cycle with an arithmetic model of the requirements.
module test_uart_chan_cfg;
    localparam int NCH = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_addr = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_addr = 1'b0;
    logic [7:0] rd_data;
    logic       baud_tick = 1'b0;
    logic [NCH-1:0] samp_8x;
    logic [NCH-1:0] chan_rst;
    logic [NCH-1:0] bit_tick;

    int n_run  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    // Model state.
    logic [7:0] m_mode = 8'h00;
    logic [7:0] m_crst = 8'h00;
    int         m_cnt [NCH];
    logic       m_seen [NCH];
    logic       m_tick [NCH];
    string      m_tag  [NCH];

    always #4 clk = ~clk;

    uart_chan_cfg i_uart_chan_cfg (
        .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .rd_addr, .rd_data,
        .baud_tick, .samp_8x, .chan_rst, .bit_tick
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    // One clock: drive at negedge, update model after posedge, check at next negedge.
    task automatic step(input logic b, input logic we, input logic a, input logic [7:0] d);
        logic [7:0] old_mode;
        logic [7:0] old_crst;
        wr_en = we; wr_addr = a; wr_data = d; baud_tick = b;
        rd_addr = cyc[0];
        @(posedge clk);
        #1;
        old_mode = m_mode;
        old_crst = m_crst;
        for (int c = 0; c < NCH; c++) begin
            m_tick[c] = 1'b0;
            if (old_crst[c] || (old_mode[c] != m_seen[c])) begin
                m_tag[c] = old_crst[c] ? "R10" : "R5";
                m_cnt[c] = 0;
                m_seen[c] = old_mode[c];
            end else if (b) begin
                if (m_cnt[c] == (old_mode[c] ? 7 : 15)) begin
                    m_cnt[c] = 0;
                    m_tick[c] = 1'b1;
                    m_tag[c] = old_mode[c] ? "R4" : "R3";
                end else begin
                    m_cnt[c]++;
                end
            end
        end
        m_crst = (we && a) ? (d & 8'h03) : 8'h00;
        if (we && !a) m_mode = d & 8'h03;
        @(negedge clk);
        cyc++;
        for (int c = 0; c < NCH; c++) begin
            chk(m_tag[c], "bit_tick", bit_tick[c], m_tick[c]);
            chk("R6", "chan_rst", chan_rst[c], m_crst[c]);
            chk("R9", "samp_8x", samp_8x[c], m_mode[c]);
        end
        chk(rd_addr ? "R6" : "R2", "rd_data", rd_data, rd_addr ? m_crst : m_mode);
        chk("R8", "reserved", rd_data[7:2], 0);
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            finish_run();
        end
    end

    initial begin
        for (int c = 0; c < NCH; c++) begin
            m_cnt[c] = 0; m_seen[c] = 1'b0; m_tick[c] = 1'b0; m_tag[c] = "R3";
        end
        repeat (3) @(negedge clk);
        // R1: reset state.
        rd_addr = 1'b0; #1;
        chk("R1", "mode reg", rd_data, 0);
        rd_addr = 1'b1; #1;
        chk("R1", "reset reg", rd_data, 0);
        chk("R1", "outputs", {samp_8x, chan_rst, bit_tick}, 0);
        rst_n = 1'b1;

        // R2 R3 R4 R5 R8: each mode value, reserved bits set, varied tick gaps.
        for (int rep = 0; rep < 2; rep++) begin
            for (int m = 0; m < 4; m++) begin
                step(1'b1, 1'b1, 1'b0, 8'(m) | 8'hFC);
                for (int i = 0; i < 60; i++)
                    step((rep == 0) ? 1'b1 : ((i % 3) != 1), 1'b0, 1'b0, 8'h00);
            end
        end

        // R5: mode flip mid-count on a continuous tick stream.
        step(1'b1, 1'b1, 1'b0, 8'h01);
        for (int i = 0; i < 11; i++) step(1'b1, 1'b0, 1'b0, 8'h00);
        step(1'b1, 1'b1, 1'b0, 8'h02);
        for (int i = 0; i < 40; i++) step(1'b1, 1'b0, 1'b0, 8'h00);

        // R6 R7 R9 R10: every reset-register byte, in both modes, ticks running.
        for (int m = 0; m < 4; m++) begin
            step(1'b0, 1'b1, 1'b0, 8'(m));
            for (int v = 0; v < 256; v++) begin
                step(1'b1, 1'b1, 1'b1, 8'(v));
                for (int i = 0; i < (v % 5); i++) step(1'b1, 1'b0, 1'b0, 8'h00);
            end
        end

        // R7: back-to-back zero writes leave the pulses low.
        for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 1'b1, 8'h00);
        step(1'b0, 1'b0, 1'b0, 8'h00);

        done = 1'b1;
        finish_run();
    end
endmodule